// File: doc/BRIEF.md
# Serial Receiver with Character-Tagged Line Status

This block receives asynchronous serial characters on a single line, using an enable pulse that arrives sixteen times per bit period. Each character has one start bit, eight data bits sent least significant bit first, an optional parity bit with even or odd sense, and one stop bit. Each received character enters a sixteen-entry queue together with its own parity-error and framing-error tags. The host sees the data byte at the head of the queue, and an 8-bit line status word that describes that head entry.

The status word also holds a sticky line-break flag and a sticky overrun flag. It also reports two transmit-side flags, which are derived from transmitter occupancy inputs and gated by a break-command input. A host read strobe on the data side pops the head entry. A host read strobe on the status side clears the error flags after the cycle in which they were seen.

Top module: `uart_rx_lsr`

## Requirements
- R1: A well-formed frame puts its data byte at the queue head on `rx_data`, and sets `line_status` bit 0 (data ready) while the queue holds at least one entry.
- R2: With `par_en` high, a parity bit that does not match the configured sense tags the character. Even sense means the data ones plus the parity bit give an even count. Odd sense (`par_odd` high) means an odd count. The tag shows as `line_status` bit 2.
- R3: A stop bit sampled as 0 tags the character with a framing error, shown as `line_status` bit 3. The receiver then waits for the line to go high before it looks for a new start bit.
- R4: Bits 2 and 3 describe only the entry at the queue head. Popping the head through `host_rd_data` brings up the tags of the next entry.
- R5: A pulse on `host_rd_status` clears bits 1, 2, 3 and 4 from the next cycle onward. Bits 2 and 3 stay clear until the head changes.
- R6: A line held low beyond one full character time stores exactly one entry of 0x00 with a framing-error tag and no parity tag. It also sets `line_status` bit 4 (break).
- R7: After a break, no character is assembled until the line has been seen high on an oversample enable. Reception then resumes normally.
- R8: A falling edge whose line is high again at the mid-start-bit sample (the 8th enable after detection) is discarded as a glitch. No entry is stored.
- R9: A character that arrives when all 16 entries are occupied is dropped, and `line_status` bit 1 (overrun) is set. The 16 earlier entries are kept in order.
- R10: `line_status` bit 5 equals `tx_hold_empty` while `tx_break_cmd` is low, and is 0 while `tx_break_cmd` is high.
- R11: `line_status` bit 6 is 1 only when `tx_hold_empty`, `tx_shift_empty` and `tx_idle` are all high and `tx_break_cmd` is low.
- R12: After reset the queue is empty, bits 0 to 4 and bit 7 are 0, and bits 5 and 6 follow the transmit inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| os_tick | input | 1 | Oversample enable, sixteen per bit period |
| rx_in | input | 1 | Serial receive line, idle high |
| par_en | input | 1 | Parity bit present in each frame |
| par_odd | input | 1 | Odd parity sense when high, even when low |
| host_rd_data | input | 1 | Pop strobe for the queue head |
| host_rd_status | input | 1 | Status read strobe, clears the error flags |
| rx_data | output | 8 | Data byte at the queue head, 0 when empty |
| line_status | output | 8 | {0, tx empty, hold empty, break, framing, parity, overrun, data ready} |
| tx_hold_empty | input | 1 | Transmit holding storage is empty |
| tx_shift_empty | input | 1 | Transmit shift register is empty |
| tx_idle | input | 1 | Transmitter is idle |
| tx_break_cmd | input | 1 | Break command asserted on the transmit side |

## Verification
The bench queues two characters, one with good parity and one with bad, and reads status before and after each pop. A design that reported the latest arrival instead of the head would show the parity flag one character too early. A low line held for forty bit times must yield exactly one null entry carrying a framing tag. A design that kept assembling frames during the break would leave several zero bytes, and one that never waited for the line to return high would store an extra entry. The bench also sends a four-enable glitch, which must store nothing, and a seventeenth character into a full queue, which must be dropped while the first sixteen survive in order. The transmit flags are compared every clock against the break command, because a design that let them rise during the command would show up in a single cycle.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  localparam int CHAR_W = 8;

  // Status bit positions
  localparam int ST_DR   = 0;
  localparam int ST_OE   = 1;
  localparam int ST_PE   = 2;
  localparam int ST_FE   = 3;
  localparam int ST_BI   = 4;
  localparam int ST_THRE = 5;
  localparam int ST_TEMT = 6;

  typedef struct packed {
    logic              pe;
    logic              fe;
    logic [CHAR_W-1:0] data;
  } rx_entry_t;

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_BRK, S_WAITHI
  } rx_state_t;

  // 1 when data plus parity bit disagree with the configured sense
  function automatic logic parity_bad(input logic [CHAR_W-1:0] d,
                                      input logic pbit, input logic odd);
    return (^d) ^ pbit ^ odd;
  endfunction

  function automatic logic hold_empty_flag(input logic hold, input logic brk);
    return hold & ~brk;
  endfunction

  function automatic logic tx_empty_flag(input logic hold, input logic shift,
                                         input logic idle, input logic brk);
    return hold & shift & idle & ~brk;
  endfunction

endpackage

// File: rtl/uart_rx_framer.sv
module uart_rx_framer
  import uart_rx_pkg::*;
#(
  parameter int OS_RATE = 16
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      os_tick,
  input  logic      rx_s,
  input  logic      par_en,
  input  logic      par_odd,
  output logic      push_vld,
  output rx_entry_t push_entry,
  output logic      brk_evt
);

  localparam int CW = $clog2(OS_RATE);
  localparam int BW = $clog2(CHAR_W);
  localparam logic [CW-1:0] MID_C  = CW'(OS_RATE/2 - 1);
  localparam logic [CW-1:0] LAST_C = CW'(OS_RATE - 1);
  localparam logic [BW-1:0] LBIT_C = BW'(CHAR_W - 1);

  rx_state_t         state;
  logic [CW-1:0]     cnt;
  logic [BW-1:0]     bit_idx;
  logic [CHAR_W-1:0] shreg;
  logic              par_bit;

  // Named internal events
  logic tick_mid, tick_end, glitch_evt, stop_zero, zero_frame, frame_pe;
  assign tick_mid   = os_tick && (cnt == MID_C);
  assign tick_end   = os_tick && (cnt == LAST_C);
  assign glitch_evt = (state == S_START) && tick_mid && rx_s;
  assign stop_zero  = (state == S_STOP) && tick_end && !rx_s;
  assign zero_frame = (shreg == '0) && (!par_en || !par_bit);
  assign frame_pe   = par_en && parity_bad(shreg, par_bit, par_odd);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      cnt        <= '0;
      bit_idx    <= '0;
      shreg      <= '0;
      par_bit    <= 1'b0;
      push_vld   <= 1'b0;
      push_entry <= '0;
      brk_evt    <= 1'b0;
    end else begin
      push_vld <= 1'b0;
      brk_evt  <= 1'b0;
      case (state)
        S_IDLE: if (os_tick && !rx_s) begin
          state <= S_START;
          cnt   <= '0;
        end
        S_START: if (os_tick) begin
          if (cnt == MID_C) begin
            cnt     <= '0;
            bit_idx <= '0;
            state   <= rx_s ? S_IDLE : S_DATA;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_DATA: if (os_tick) begin
          cnt <= (cnt == LAST_C) ? '0 : cnt + 1'b1;
          if (tick_end) begin
            shreg <= {rx_s, shreg[CHAR_W-1:1]};
            if (bit_idx == LBIT_C) state <= par_en ? S_PAR : S_STOP;
            else                   bit_idx <= bit_idx + 1'b1;
          end
        end
        S_PAR: if (os_tick) begin
          cnt <= (cnt == LAST_C) ? '0 : cnt + 1'b1;
          if (tick_end) begin
            par_bit <= rx_s;
            state   <= S_STOP;
          end
        end
        S_STOP: if (os_tick) begin
          cnt <= (cnt == LAST_C) ? '0 : cnt + 1'b1;
          if (tick_end) begin
            if (rx_s) begin
              push_vld   <= 1'b1;
              push_entry <= '{pe: frame_pe, fe: 1'b0, data: shreg};
              state      <= S_IDLE;
            end else if (zero_frame) begin
              state <= S_BRK;
            end else begin
              push_vld   <= 1'b1;
              push_entry <= '{pe: frame_pe, fe: 1'b1, data: shreg};
              state      <= S_WAITHI;
            end
          end
        end
        S_BRK: if (os_tick) begin
          if (rx_s) begin
            // short all-zero frame: plain framing error
            push_vld   <= 1'b1;
            push_entry <= '{pe: frame_pe, fe: 1'b1, data: shreg};
            state      <= S_IDLE;
          end else if (cnt == LAST_C) begin
            push_vld   <= 1'b1;
            push_entry <= '{pe: 1'b0, fe: 1'b1, data: '0};
            brk_evt    <= 1'b1;
            state      <= S_WAITHI;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_WAITHI: if (os_tick && rx_s) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  p_glitch_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    glitch_evt |=> (state == S_IDLE) && !push_vld);

  p_fe_tag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_zero && !zero_frame) |=> push_vld && push_entry.fe);

  p_brk_null_r6: assert property (@(posedge clk) disable iff (!rst_n)
    brk_evt |-> push_vld && (push_entry.data == '0) && push_entry.fe && !push_entry.pe);

  p_wait_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == S_WAITHI) && !rx_s) |=> (state == S_WAITHI) && !push_vld);

endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo
  import uart_rx_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      push,
  input  rx_entry_t wr_entry,
  input  logic      pop,
  output rx_entry_t head,
  output logic      empty,
  output logic      full,
  output logic      overrun_evt
);

  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0]   DEPTH_C = (AW+1)'(DEPTH);
  localparam logic [AW-1:0] LASTP_C = AW'(DEPTH - 1);

  rx_entry_t     mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [AW:0]   count;
  logic          push_ok, pop_ok;

  assign empty       = (count == '0);
  assign full        = (count == DEPTH_C);
  assign push_ok     = push && !full;
  assign pop_ok      = pop && !empty;
  assign overrun_evt = push && full;
  assign head        = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= wr_entry;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= (wr_ptr == LASTP_C) ? '0 : wr_ptr + 1'b1;
      if (pop_ok)  rd_ptr <= (rd_ptr == LASTP_C) ? '0 : rd_ptr + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  p_overrun_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun_evt && !pop) |=> full);

  p_ready_after_push_r1: assert property (@(posedge clk) disable iff (!rst_n)
    push_ok |=> !empty);

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    count <= DEPTH_C);

endmodule

// File: rtl/uart_rx_lsr.sv
module uart_rx_lsr
  import uart_rx_pkg::*;
#(
  parameter int OS_RATE    = 16,
  parameter int FIFO_DEPTH = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        os_tick,
  input  logic        rx_in,
  input  logic        par_en,
  input  logic        par_odd,
  input  logic        host_rd_data,
  input  logic        host_rd_status,
  output logic [7:0]  rx_data,
  output logic [7:0]  line_status,
  input  logic        tx_hold_empty,
  input  logic        tx_shift_empty,
  input  logic        tx_idle,
  input  logic        tx_break_cmd
);

  logic      rx_m, rx_s;
  logic      push_vld, brk_evt;
  rx_entry_t push_entry, head;
  logic      fifo_empty, fifo_full, overrun_evt;
  logic      ack_q, oe_q, bi_q;
  logic      head_pe, head_fe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_m <= 1'b1;
      rx_s <= 1'b1;
    end else begin
      rx_m <= rx_in;
      rx_s <= rx_m;
    end
  end

  uart_rx_framer #(.OS_RATE(OS_RATE)) u_framer (
    .clk        (clk),
    .rst_n      (rst_n),
    .os_tick    (os_tick),
    .rx_s       (rx_s),
    .par_en     (par_en),
    .par_odd    (par_odd),
    .push_vld   (push_vld),
    .push_entry (push_entry),
    .brk_evt    (brk_evt)
  );

  uart_rx_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk         (clk),
    .rst_n       (rst_n),
    .push        (push_vld),
    .wr_entry    (push_entry),
    .pop         (host_rd_data),
    .head        (head),
    .empty       (fifo_empty),
    .full        (fifo_full),
    .overrun_evt (overrun_evt)
  );

  // Sticky flags; a new event wins over a same-cycle status read
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q <= 1'b0;
      oe_q  <= 1'b0;
      bi_q  <= 1'b0;
    end else begin
      bi_q <= brk_evt ? 1'b1 : (host_rd_status ? 1'b0 : bi_q);
      oe_q <= overrun_evt ? 1'b1 : (host_rd_status ? 1'b0 : oe_q);
      if (fifo_empty || host_rd_data) ack_q <= 1'b0;
      else if (host_rd_status)        ack_q <= 1'b1;
    end
  end

  assign head_pe = !fifo_empty && head.pe && !ack_q;
  assign head_fe = !fifo_empty && head.fe && !ack_q;
  assign rx_data = fifo_empty ? '0 : head.data;

  always_comb begin
    line_status          = '0;
    line_status[ST_DR]   = !fifo_empty;
    line_status[ST_OE]   = oe_q;
    line_status[ST_PE]   = head_pe;
    line_status[ST_FE]   = head_fe;
    line_status[ST_BI]   = bi_q;
    line_status[ST_THRE] = hold_empty_flag(tx_hold_empty, tx_break_cmd);
    line_status[ST_TEMT] = tx_empty_flag(tx_hold_empty, tx_shift_empty, tx_idle, tx_break_cmd);
  end

  p_bi_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd_status && !brk_evt) |=> !line_status[ST_BI]);

  p_err_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd_status && !host_rd_data && !fifo_empty) |=>
      !line_status[ST_PE] && !line_status[ST_FE]);

  p_brk_sets_bi_r6: assert property (@(posedge clk) disable iff (!rst_n)
    brk_evt |=> line_status[ST_BI] && line_status[ST_DR]);

  p_overrun_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_evt |=> line_status[ST_OE]);

endmodule

// File: tb/tb_uart_rx_lsr.sv
module tb_uart_rx_lsr;

  localparam int TPB = 4;          // clocks per oversample enable
  localparam int BITC = 16 * TPB;  // clocks per bit

  typedef struct { logic [7:0] d; bit pe; bit fe; } exp_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic os_tick = 1'b0, rx_in = 1'b1, par_en = 1'b0, par_odd = 1'b0;
  logic host_rd_data = 1'b0, host_rd_status = 1'b0;
  logic tx_hold_empty = 1'b1, tx_shift_empty = 1'b1, tx_idle = 1'b1, tx_break_cmd = 1'b0;
  logic [7:0] rx_data, line_status;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  exp_t exp_q[$];

  always #2.5 clk = ~clk;

  uart_rx_lsr dut (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rx_in(rx_in),
    .par_en(par_en), .par_odd(par_odd),
    .host_rd_data(host_rd_data), .host_rd_status(host_rd_status),
    .rx_data(rx_data), .line_status(line_status),
    .tx_hold_empty(tx_hold_empty), .tx_shift_empty(tx_shift_empty),
    .tx_idle(tx_idle), .tx_break_cmd(tx_break_cmd)
  );

  int tick_div = 0;
  always @(negedge clk) begin
    tick_div = (tick_div == TPB - 1) ? 0 : tick_div + 1;
    os_tick <= (tick_div == 0);
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Transmit flags compared on every clock (R10, R11)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R10 hold-empty flag", line_status[5], tx_hold_empty && !tx_break_cmd);
      check("R11 tx-empty flag", line_status[6],
            tx_hold_empty && tx_shift_empty && tx_idle && !tx_break_cmd);
    end
  end

  task automatic bit_time(input logic v, input int n);
    rx_in = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input bit bad_par, input bit stop_v);
    bit pb;
    pb = (^d) ^ par_odd ^ bad_par;
    bit_time(1'b0, BITC);
    for (int i = 0; i < 8; i++) bit_time(d[i], BITC);
    if (par_en) bit_time(pb, BITC);
    bit_time(stop_v, BITC);
    bit_time(1'b1, 2 * BITC);
    exp_q.push_back('{d: d, pe: par_en && bad_par, fe: !stop_v});
  endtask

  task automatic rd_status(output logic [7:0] s);
    @(negedge clk);
    host_rd_status = 1'b1;
    #1 s = line_status;
    @(negedge clk);
    host_rd_status = 1'b0;
  endtask

  task automatic pop(input string req);
    exp_t e;
    @(negedge clk);
    host_rd_data = 1'b1;
    e = exp_q.pop_front();
    #1 check(req, rx_data, e.d);
    @(negedge clk);
    host_rd_data = 1'b0;
  endtask

  initial begin
    logic [7:0] s;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R12 reset state
    check("R12 reset status", line_status, 8'h60);
    check("R12 reset data", rx_data, 8'h00);

    // R1 plain frame
    send(8'hA5, 0, 1);
    rd_status(s); check("R1 data ready", s, 8'h61);
    pop("R1 head data");
    rd_status(s); check("R1 empty after pop", s, 8'h60);

    // R2/R4 parity tags travel with entries
    par_en = 1'b1; par_odd = 1'b0;
    send(8'h3C, 0, 1);
    send(8'h81, 1, 1);
    rd_status(s); check("R4 head clean while bad entry queued", s, 8'h61);
    pop("R4 first entry");
    rd_status(s); check("R2 R4 parity flag of new head", s, 8'h65);
    rd_status(s); check("R5 parity cleared by status read", s, 8'h61);
    pop("R2 bad-parity data");
    par_odd = 1'b1;
    send(8'h7E, 0, 1);
    rd_status(s); check("R2 odd parity accepted", s, 8'h61);
    pop("R2 odd data");
    send(8'h7E, 1, 1);
    rd_status(s); check("R2 odd parity error", s, 8'h65);
    pop("R2 odd bad data");
    par_en = 1'b0; par_odd = 1'b0;

    // R3 framing error
    send(8'h42, 0, 0);
    rd_status(s); check("R3 framing flag", s, 8'h69);
    pop("R3 data with framing error");
    rd_status(s); check("R3 no extra entry", s, 8'h60);

    // R8 glitch
    bit_time(1'b0, 4 * TPB);
    bit_time(1'b1, 3 * BITC);
    rd_status(s); check("R8 glitch ignored", s, 8'h60);

    // R6/R7 break
    bit_time(1'b0, 40 * BITC);
    bit_time(1'b1, 2 * BITC);
    exp_q.push_back('{d: 8'h00, pe: 0, fe: 1});
    rd_status(s); check("R6 break with null entry", s, 8'h79);
    rd_status(s); check("R5 break and framing cleared", s, 8'h61);
    pop("R6 null data");
    rd_status(s); check("R7 exactly one entry", s, 8'h60);
    send(8'h99, 0, 1);
    pop("R7 reception resumes");

    // R9 overrun
    for (int i = 0; i < 17; i++) send(8'h10 + 8'(i), 0, 1);
    void'(exp_q.pop_back());
    rd_status(s); check("R9 overrun flag", s, 8'h63);
    rd_status(s); check("R5 overrun cleared", s, 8'h61);
    for (int i = 0; i < 16; i++) pop("R9 order kept");
    rd_status(s); check("R9 extra character dropped", s, 8'h60);

    // R10/R11 explicit combinations
    tx_break_cmd = 1'b1; #1 check("R10 R11 break holds flags low", line_status[6:5], 2'b00);
    @(negedge clk); tx_break_cmd = 1'b0; #1 check("R10 R11 released", line_status[6:5], 2'b11);
    @(negedge clk); tx_shift_empty = 1'b0; #1 check("R11 shift busy", line_status[6:5], 2'b01);
    @(negedge clk); tx_hold_empty = 1'b0; #1 check("R10 holding busy", line_status[6:5], 2'b00);
    @(negedge clk); tx_hold_empty = 1'b1; tx_shift_empty = 1'b1; tx_idle = 1'b0;
    #1 check("R11 not idle", line_status[6:5], 2'b01);
    @(negedge clk);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule